// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit sits after instruction decode in a 64-bit-register packet-filter style processor. It takes the current program counter, a jump kind, a condition code, two compare operands and a signed displacement. From these it works out whether control flow leaves the sequential path, and where it goes. The program counter counts 64-bit instruction words. Every jump target is measured from the instruction after the jump, so a displacement of zero selects the sequential instruction.

The result is registered. One cycle after `in_valid`, the unit presents a taken flag, the next program counter and an illegal-instruction flag. For call and exit instructions it only raises a marker and leaves them to the sequencer. A compile-time ISA level decides whether the 32-bit compare variants are accepted.

Top module: `bru_resolve`

## Requirements
- R1: For a conditional jump (`in_kind` = 0), `in_cond` selects the test between operand A and operand B. The codes are: 0 equal, 1 not equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 unsigned less, 5 unsigned less-or-equal, 6 signed greater, 7 signed greater-or-equal, 8 signed less, 9 signed less-or-equal, 10 bit test. The bit test is true when A AND B is nonzero.
- R2: When `in_use_imm` is 1, operand B is `in_imm` sign-extended to 64 bits and `in_opb` has no effect. When `in_use_imm` is 0, operand B is `in_opb`.
- R3: When `in_narrow` is 1, a conditional jump compares only bits 31:0 of both operands. Bit 31 is the sign for the signed tests.
- R4: A narrow conditional jump is legal only if `ISA_LEVEL` is 3 or more. Otherwise it reports illegal and not taken.
- R5: A taken conditional jump, and a short unconditional jump (`in_kind` = 1), go to PC + 1 + sign-extended `in_disp[15:0]`. Bits 31:16 of `in_disp` are ignored.
- R6: A long unconditional jump (`in_kind` = 2) is always taken and goes to PC + 1 + sign-extended `in_disp[31:0]`.
- R7: Whenever the result is not taken, the next PC is PC + 1. All PC arithmetic wraps modulo 2^PC_W.
- R8: A call (`in_kind` = 3) raises `out_call`, and an exit (`in_kind` = 4) raises `out_exit`. Both report not taken, not illegal and a next PC of PC + 1.
- R9: Condition codes 11 to 15 on a conditional jump, and kind codes 5 to 7, raise `out_illegal` with not taken and a next PC of PC + 1. At most one of taken, illegal, call and exit is ever high.
- R10: Results appear on the clock edge after the input was accepted, qualified by `out_valid`. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input fields carry a jump to resolve |
| in_pc | input | PC_W | Word address of the jump |
| in_kind | input | 3 | 0 cond, 1 short jump, 2 long jump, 3 call, 4 exit |
| in_cond | input | 4 | Condition code for kind 0 |
| in_narrow | input | 1 | Compare low 32 bits only |
| in_use_imm | input | 1 | Operand B from immediate |
| in_opa | input | DATA_W | Operand A |
| in_opb | input | DATA_W | Operand B register value |
| in_imm | input | IMM_W | Immediate for operand B |
| in_disp | input | DISP_W | Signed word displacement |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Control leaves the sequential path |
| out_next_pc | output | PC_W | Next program counter |
| out_illegal | output | 1 | Instruction rejected |
| out_call | output | 1 | Call seen |
| out_exit | output | 1 | Exit seen |

## Verification
The bench builds two copies with `PC_W` = 24. One uses `ISA_LEVEL` = 4 and the other `ISA_LEVEL` = 2, and both are driven with the same stimulus, so every narrow compare checks legality on one copy and the compare result on the other. A 24-bit PC is short enough that the bench can drive wrap-around past the top of the PC range, and long enough to show whether displacement bits 16 and up are used. The sweep covers all sixteen condition codes, both widths and both operand-B sources, across sixteen boundary operand values. These values include the 32-bit and 64-bit sign boundaries.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    K_COND = 3'd0,
    K_JMP  = 3'd1,
    K_JMPL = 3'd2,
    K_CALL = 3'd3,
    K_EXIT = 3'd4
  } kind_e;

  typedef enum logic [3:0] {
    C_EQ  = 4'd0,
    C_NE  = 4'd1,
    C_UGT = 4'd2,
    C_UGE = 4'd3,
    C_ULT = 4'd4,
    C_ULE = 4'd5,
    C_SGT = 4'd6,
    C_SGE = 4'd7,
    C_SLT = 4'd8,
    C_SLE = 4'd9,
    C_SET = 4'd10
  } cond_e;

  localparam int unsigned COND_LAST     = 10;
  localparam int unsigned NARROW_MIN_ISA = 3;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [3:0]        cond,
  input  logic              narrow,
  output logic              hit
);
  localparam int unsigned PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] ua, ub;
  logic [DATA_W-1:0] sa, sb;
  logic eq, lt_u, lt_s, any_bit;

  // Zero-extended view drives the unsigned tests; sign-extended view the signed ones.
  always_comb begin
    if (narrow) begin
      ua = {{PAD_W{1'b0}}, opa[NARROW_W-1:0]};
      ub = {{PAD_W{1'b0}}, opb[NARROW_W-1:0]};
      sa = {{PAD_W{opa[NARROW_W-1]}}, opa[NARROW_W-1:0]};
      sb = {{PAD_W{opb[NARROW_W-1]}}, opb[NARROW_W-1:0]};
    end else begin
      ua = opa;
      ub = opb;
      sa = opa;
      sb = opb;
    end
  end

  assign eq      = (ua == ub);
  assign lt_u    = (ua < ub);
  assign lt_s    = ($signed(sa) < $signed(sb));
  assign any_bit = |(ua & ub);

  always_comb begin
    unique case (cond)
      C_EQ:    hit = eq;
      C_NE:    hit = !eq;
      C_UGT:   hit = !lt_u && !eq;
      C_UGE:   hit = !lt_u;
      C_ULT:   hit = lt_u;
      C_ULE:   hit = lt_u || eq;
      C_SGT:   hit = !lt_s && !eq;
      C_SGE:   hit = !lt_s;
      C_SLT:   hit = lt_s;
      C_SLE:   hit = lt_s || eq;
      C_SET:   hit = any_bit;
      default: hit = 1'b0;
    endcase
  end

  // R1: equality and strict ordering never coincide
  always_comb begin
    a_order_excl_r1: assert (!(eq && (lt_u || lt_s)));
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int unsigned PC_W    = 64,
  parameter int unsigned DISP_W  = 32,
  parameter int unsigned SHORT_W = 16
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              long_sel,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   tgt_pc
);
  localparam int unsigned EXT_W = PC_W + DISP_W;

  logic [EXT_W-1:0] ext_short, ext_long, ext_sel;

  assign ext_short = {{(EXT_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign ext_long  = {{(EXT_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign ext_sel   = long_sel ? ext_long : ext_short;

  assign seq_pc = pc + PC_W'(1);
  assign tgt_pc = seq_pc + ext_sel[PC_W-1:0];
endmodule

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int unsigned ISA_LEVEL = 4
) (
  input  logic [2:0] kind,
  input  logic [3:0] cond,
  input  logic       narrow,
  output logic       cond_en,
  output logic       uncond,
  output logic       long_sel,
  output logic       is_call,
  output logic       is_exit,
  output logic       illegal
);
  localparam bit NARROW_OK = (ISA_LEVEL >= NARROW_MIN_ISA);

  always_comb begin
    cond_en  = 1'b0;
    uncond   = 1'b0;
    long_sel = 1'b0;
    is_call  = 1'b0;
    is_exit  = 1'b0;
    illegal  = 1'b0;
    unique case (kind)
      K_COND: begin
        if (32'(cond) > COND_LAST)        illegal = 1'b1;
        else if (narrow && !NARROW_OK)    illegal = 1'b1;
        else                              cond_en = 1'b1;
      end
      K_JMP:  uncond = 1'b1;
      K_JMPL: begin
        uncond   = 1'b1;
        long_sel = 1'b1;
      end
      K_CALL: is_call = 1'b1;
      K_EXIT: is_exit = 1'b1;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
#(
  parameter int unsigned PC_W      = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned IMM_W     = 32,
  parameter int unsigned DISP_W    = 32,
  parameter int unsigned SHORT_W   = 16,
  parameter int unsigned NARROW_W  = 32,
  parameter int unsigned ISA_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [2:0]        in_kind,
  input  logic [3:0]        in_cond,
  input  logic              in_narrow,
  input  logic              in_use_imm,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_illegal,
  output logic              out_call,
  output logic              out_exit
);
  localparam int unsigned IMM_PAD = DATA_W - IMM_W;

  logic [DATA_W-1:0] opb_sel;
  logic              cond_en, uncond, long_sel, is_call, is_exit, illegal;
  logic              hit;
  logic [PC_W-1:0]   seq_pc, tgt_pc;

  logic              taken_d;
  logic [PC_W-1:0]   next_pc_d;

  logic              valid_q, taken_q, illegal_q, call_q, exit_q;
  logic [PC_W-1:0]   next_pc_q;

  assign opb_sel = in_use_imm ? {{IMM_PAD{in_imm[IMM_W-1]}}, in_imm} : in_opb;

  bru_decode #(.ISA_LEVEL(ISA_LEVEL)) u_dec (
    .kind     (in_kind),
    .cond     (in_cond),
    .narrow   (in_narrow),
    .cond_en  (cond_en),
    .uncond   (uncond),
    .long_sel (long_sel),
    .is_call  (is_call),
    .is_exit  (is_exit),
    .illegal  (illegal)
  );

  bru_cond_eval #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cmp (
    .opa    (in_opa),
    .opb    (opb_sel),
    .cond   (in_cond),
    .narrow (in_narrow),
    .hit    (hit)
  );

  bru_target #(.PC_W(PC_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W)) u_tgt (
    .pc       (in_pc),
    .disp     (in_disp),
    .long_sel (long_sel),
    .seq_pc   (seq_pc),
    .tgt_pc   (tgt_pc)
  );

  // next-state
  always_comb begin
    taken_d   = uncond || (cond_en && hit);
    next_pc_d = taken_d ? tgt_pc : seq_pc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      taken_q   <= 1'b0;
      illegal_q <= 1'b0;
      call_q    <= 1'b0;
      exit_q    <= 1'b0;
      next_pc_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        taken_q   <= taken_d;
        illegal_q <= illegal;
        call_q    <= is_call;
        exit_q    <= is_exit;
        next_pc_q <= next_pc_d;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_taken   = taken_q;
  assign out_illegal = illegal_q;
  assign out_call    = call_q;
  assign out_exit    = exit_q;
  assign out_next_pc = next_pc_q;

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_taken, out_illegal, out_call, out_exit}));

  p_seq_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !taken_d) |=> (out_next_pc == $past(in_pc) + PC_W'(1)));

  p_jump_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_kind == K_JMP || in_kind == K_JMPL)) |=> out_taken);

  p_call_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == K_CALL) |=> (out_call && !out_taken));

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  generate
    if (ISA_LEVEL < NARROW_MIN_ISA) begin : g_old_isa
      p_narrow_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == K_COND && in_narrow) |=> (out_illegal && !out_taken));
    end
  endgenerate
endmodule

// File: tb/bru_resolve_test.sv
`timescale 1ns/1ps
module bru_resolve_test;
  localparam int PW = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_narrow, in_use_imm;
  logic [PW-1:0] in_pc;
  logic [2:0] in_kind;
  logic [3:0] in_cond;
  logic [63:0] in_opa, in_opb;
  logic [31:0] in_imm, in_disp;

  logic n_valid, n_taken, n_ill, n_call, n_exit;
  logic [PW-1:0] n_pc;
  logic o_valid, o_taken, o_ill, o_call, o_exit;
  logic [PW-1:0] o_pc;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bru_resolve #(.PC_W(PW), .ISA_LEVEL(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_kind(in_kind),
    .in_cond(in_cond), .in_narrow(in_narrow), .in_use_imm(in_use_imm), .in_opa(in_opa),
    .in_opb(in_opb), .in_imm(in_imm), .in_disp(in_disp), .out_valid(n_valid),
    .out_taken(n_taken), .out_next_pc(n_pc), .out_illegal(n_ill), .out_call(n_call),
    .out_exit(n_exit));

  bru_resolve #(.PC_W(PW), .ISA_LEVEL(2)) uut_v2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_kind(in_kind),
    .in_cond(in_cond), .in_narrow(in_narrow), .in_use_imm(in_use_imm), .in_opa(in_opa),
    .in_opb(in_opb), .in_imm(in_imm), .in_disp(in_disp), .out_valid(o_valid),
    .out_taken(o_taken), .out_next_pc(o_pc), .out_illegal(o_ill), .out_call(o_call),
    .out_exit(o_exit));

  function automatic logic [63:0] pat(int i);
    case (i)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'h2;
      3:  return 64'hFFFF_FFFF_FFFF_FFFF;
      4:  return 64'hFFFF_FFFF_FFFF_FFFE;
      5:  return 64'h0000_0000_7FFF_FFFF;
      6:  return 64'h0000_0000_8000_0000;
      7:  return 64'h0000_0000_FFFF_FFFF;
      8:  return 64'h0000_0001_0000_0000;
      9:  return 64'h7FFF_FFFF_FFFF_FFFF;
      10: return 64'h8000_0000_0000_0000;
      11: return 64'h0000_0001_8000_0000;
      12: return 64'hFFFF_FFFF_0000_0001;
      13: return 64'h1234_5678_9ABC_DEF0;
      14: return 64'hFFFF_FFFF_8000_0000;
      default: return 64'h0000_0000_0000_0003;
    endcase
  endfunction

  function automatic bit ref_hit(int c, bit nar, logic [63:0] a, logic [63:0] b);
    logic [63:0] ua, ub;
    logic signed [63:0] sa, sb;
    if (nar) begin
      ua = {32'h0, a[31:0]};
      ub = {32'h0, b[31:0]};
      sa = {{32{a[31]}}, a[31:0]};
      sb = {{32{b[31]}}, b[31:0]};
    end else begin
      ua = a; ub = b; sa = a; sb = b;
    end
    case (c)
      0: return ua == ub;
      1: return ua != ub;
      2: return ua > ub;
      3: return ua >= ub;
      4: return ua < ub;
      5: return ua <= ub;
      6: return sa > sb;
      7: return sa >= sb;
      8: return sa < sb;
      9: return sa <= sb;
      10: return (ua & ub) != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, string who, logic v, logic t, logic [PW-1:0] p,
                     logic il, logic cl, logic ex, bit et, logic [PW-1:0] ep,
                     bit eil, bit ecl, bit eex);
    vectors++;
    if (v !== 1'b1 || t !== et || p !== ep || il !== eil || cl !== ecl || ex !== eex) begin
      fails++;
      $display("FAIL %s %s: got v%0b t%0b pc=%h il%0b c%0b e%0b exp t%0b pc=%h il%0b c%0b e%0b",
               req, who, v, t, p, il, cl, ex, et, ep, eil, ecl, eex);
    end
  endtask

  task automatic drive(logic [PW-1:0] pc, logic [2:0] k, logic [3:0] c, bit nar,
                       bit ui, logic [63:0] a, logic [63:0] b, logic [31:0] im,
                       logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_pc = pc; in_kind = k; in_cond = c; in_narrow = nar;
    in_use_imm = ui; in_opa = a; in_opb = b; in_imm = im; in_disp = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [PW-1:0] pc, seq, tgt;
    logic [31:0] d;
    logic [63:0] bval;
    bit h, il_n, il_o;
    rst_n = 1'b0; in_valid = 1'b0; in_pc = '0; in_kind = '0; in_cond = '0;
    in_narrow = 1'b0; in_use_imm = 1'b0; in_opa = '0; in_opb = '0; in_imm = '0; in_disp = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    vectors++;
    if (n_valid !== 1'b0 || n_taken !== 1'b0 || n_pc !== '0 || n_ill !== 1'b0 ||
        n_call !== 1'b0 || n_exit !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: v%0b t%0b pc=%h exp all zero", n_valid, n_taken, n_pc);
    end
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R7 R9: full condition sweep
    n = 0;
    for (int c = 0; c < 16; c++)
      for (int nar = 0; nar < 2; nar++)
        for (int ui = 0; ui < 2; ui++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
              pc = PW'(n * 977 + 5);
              d  = {16'hA5A5, 16'(n * 40503)};
              bval = ui ? {{32{pat(j)[31]}}, pat(j)[31:0]} : pat(j);
              h = ref_hit(c, nar[0], pat(i), bval);
              il_n = (c > 10);
              il_o = il_n || nar[0];
              seq = pc + 1'b1;
              tgt = seq + {{(PW-16){d[15]}}, d[15:0]};
              drive(pc, 3'd0, 4'(c), nar[0], ui[0], pat(i),
                    ui ? ~pat(j) : pat(j), pat(j)[31:0], d);
              chk("R1/R2/R3/R5", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit,
                  !il_n && h, (!il_n && h) ? tgt : seq, il_n, 1'b0, 1'b0);
              chk("R4/R9", "uut_v2", o_valid, o_taken, o_pc, o_ill, o_call, o_exit,
                  !il_o && h, (!il_o && h) ? tgt : seq, il_o, 1'b0, 1'b0);
              n++;
            end

    // R5: short jump ignores upper displacement bits
    drive(24'h000100, 3'd1, 4'd0, 1'b0, 1'b0, '0, '0, '0, 32'h7FFF_FFFD);
    chk("R5", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit, 1'b1, 24'h0000FE, 0, 0, 0);
    // R7: wrap past top of PC range
    drive(24'hFFFFFF, 3'd1, 4'd0, 1'b0, 1'b0, '0, '0, '0, 32'h0000_0000);
    chk("R7", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit, 1'b1, 24'h000000, 0, 0, 0);
    // R6: long jump uses all 32 bits; narrow bit irrelevant on old ISA
    drive(24'h000010, 3'd2, 4'd15, 1'b1, 1'b0, '0, '0, '0, 32'h0001_0000);
    chk("R6", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit, 1'b1, 24'h010011, 0, 0, 0);
    chk("R6", "uut_v2", o_valid, o_taken, o_pc, o_ill, o_call, o_exit, 1'b1, 24'h010011, 0, 0, 0);
    drive(24'h000100, 3'd2, 4'd0, 1'b0, 1'b0, '0, '0, '0, 32'hFFFF_FFFD);
    chk("R6", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit, 1'b1, 24'h0000FE, 0, 0, 0);
    // R8: call and exit
    drive(24'h123456, 3'd3, 4'd0, 1'b0, 1'b0, '0, '0, '0, 32'h0000_0040);
    chk("R8", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit, 1'b0, 24'h123457, 0, 1, 0);
    drive(24'hFFFFFF, 3'd4, 4'd0, 1'b0, 1'b0, '0, '0, '0, 32'h0000_0040);
    chk("R8", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit, 1'b0, 24'h000000, 0, 0, 1);
    // R9: undefined kinds
    for (int k = 5; k < 8; k++) begin
      drive(24'h000200, 3'(k), 4'd0, 1'b0, 1'b0, '0, '0, '0, 32'h0000_0010);
      chk("R9", "uut", n_valid, n_taken, n_pc, n_ill, n_call, n_exit, 1'b0, 24'h000201, 1, 0, 0);
    end
    // R10: idle cycle drops valid
    @(negedge clk);
    vectors++;
    if (n_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle: got v%0b exp 0", n_valid);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule